// File: doc/BRIEF.md
# Branch Target Generator

This block computes the next fetch address for a branch in a machine whose instructions are all 32 bits wide. Because the branch label must fit inside the instruction word, a relative branch carries a signed 21-bit displacement counted in words. That displacement is added to the base of the current fetch packet. An absolute branch instead takes its full 32-bit destination from a register operand. Only one shift unit may issue the absolute form. A request from any other unit is reported as an illegal-unit error.

Each request is a single beat on a valid/ready input. The result is one registered beat on a valid/ready output. It carries the target, a taken flag and the illegal-unit flag. A branch whose predicate is false, or whose issuing unit is illegal, is not taken. In that case the target output keeps the last taken destination. The input is ready whenever the output register is empty or being drained, so `req_ready = !out_valid || out_ready`. While the output holds a beat that the consumer has not accepted, no new request is taken and every output stays frozen.

Top module: `btg_top`

## Requirements
- R1: After reset, out_valid, out_taken and out_bad_unit are 0 and out_target is 0.
- R2: A taken relative request (req_abs=0) from any unit produces out_target = (req_pc with bits 4:0 cleared) + sign-extended req_disp × 4, computed modulo 2^32.
- R3: The relative displacement is two's complement over 21 bits. 0x1FFFFF moves back one word, 0x100000 moves back 2^22 bytes, 0x0FFFFF moves forward 0x3FFFFC bytes, and a sum past 0xFFFFFFFF wraps.
- R4: A taken absolute request (req_abs=1) from unit code 3 produces out_target = req_reg with bits 1:0 cleared.
- R5: An absolute request whose req_unit is not 3 gives out_bad_unit=1 and out_taken=0, and it leaves out_target unchanged, whatever the predicate. The unit codes are 0..7, and code 3 is the second shift unit.
- R6: A legal request with req_pred=0 gives out_taken=0 and out_bad_unit=0, and it leaves out_target unchanged.
- R7: A request accepted at a clock edge (req_valid and req_ready both high) appears with out_valid=1 right after that edge. out_valid returns to 0 after an edge with out_ready=1 and no accepted request.
- R8: While out_valid=1 and out_ready=0, req_ready is 0, the pending request is not consumed, and out_target, out_taken and out_bad_unit stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_pc | input | 32 | Fetch address of the branch |
| req_disp | input | 21 | Signed word displacement from the opcode |
| req_reg | input | 32 | Register operand for the absolute form |
| req_abs | input | 1 | 1 = absolute (register) form, 0 = relative form |
| req_unit | input | 3 | Code of the issuing unit (3 = second shift unit) |
| req_pred | input | 1 | Predicate enable; branch is taken only when 1 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts the result beat |
| out_target | output | 32 | Last taken branch destination |
| out_taken | output | 1 | Result beat is a taken branch |
| out_bad_unit | output | 1 | Absolute form issued from an illegal unit |

## Verification
The bench targets the sign boundary of the displacement. A design that zero-extends the field jumps about 4 MB forward where it should step back. It also targets fetch addresses with nonzero low bits: a design that forgets to clear bits 4:0 lands up to 31 bytes off. Register targets with odd low bits catch a missing word alignment. Absolute requests from a wrong unit, with the predicate either set or clear, expose a design that branches anyway or overwrites the held target. A stall with a second request waiting shows whether a design drops or overwrites a beat under back-pressure.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int ADDR_W   = 32;
  localparam int DISP_W   = 21;
  localparam int UNIT_W   = 3;
  localparam int PKT_LSB  = 5;
  localparam int WORD_LSB = 2;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_L1 = 3'd0,
    UNIT_L2 = 3'd1,
    UNIT_S1 = 3'd2,
    UNIT_S2 = 3'd3,
    UNIT_M1 = 3'd4,
    UNIT_M2 = 3'd5,
    UNIT_D1 = 3'd6,
    UNIT_D2 = 3'd7
  } exec_unit_e;
endpackage

// File: rtl/btg_rel_calc.sv
module btg_rel_calc #(
  parameter int ADDR_W   = btg_pkg::ADDR_W,
  parameter int DISP_W   = btg_pkg::DISP_W,
  parameter int PKT_LSB  = btg_pkg::PKT_LSB,
  parameter int WORD_LSB = btg_pkg::WORD_LSB
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] PKT_MASK = ADDR_W'((64'd1 << PKT_LSB) - 64'd1);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    base   = pc & ~PKT_MASK;
    offset = {{EXT_W{disp[DISP_W-1]}}, disp} << WORD_LSB;
    target = base + offset;
  end
endmodule

// File: rtl/btg_abs_align.sv
module btg_abs_align #(
  parameter int ADDR_W   = btg_pkg::ADDR_W,
  parameter int WORD_LSB = btg_pkg::WORD_LSB
) (
  input  logic [ADDR_W-1:0] reg_val,
  output logic [ADDR_W-1:0] target
);
  always_comb target = {reg_val[ADDR_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
endmodule

// File: rtl/btg_unit_check.sv
module btg_unit_check #(
  parameter int UNIT_W = btg_pkg::UNIT_W,
  parameter logic [UNIT_W-1:0] ABS_UNIT = btg_pkg::UNIT_S2
) (
  input  logic              abs_mode,
  input  logic [UNIT_W-1:0] unit,
  output logic              legal
);
  always_comb legal = !abs_mode || (unit == ABS_UNIT);
endmodule

// File: rtl/btg_top.sv
module btg_top #(
  parameter int ADDR_W   = btg_pkg::ADDR_W,
  parameter int DISP_W   = btg_pkg::DISP_W,
  parameter int UNIT_W   = btg_pkg::UNIT_W,
  parameter int PKT_LSB  = btg_pkg::PKT_LSB,
  parameter int WORD_LSB = btg_pkg::WORD_LSB,
  parameter logic [UNIT_W-1:0] ABS_UNIT = btg_pkg::UNIT_S2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic              req_abs,
  input  logic [UNIT_W-1:0] req_unit,
  input  logic              req_pred,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_taken,
  output logic              out_bad_unit
);
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] abs_tgt;
  logic              legal;
  logic              accept;
  logic              take;

  btg_rel_calc #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .PKT_LSB(PKT_LSB), .WORD_LSB(WORD_LSB)
  ) u_rel (
    .pc(req_pc), .disp(req_disp), .target(rel_tgt)
  );

  btg_abs_align #(
    .ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)
  ) u_abs (
    .reg_val(req_reg), .target(abs_tgt)
  );

  btg_unit_check #(
    .UNIT_W(UNIT_W), .ABS_UNIT(ABS_UNIT)
  ) u_chk (
    .abs_mode(req_abs), .unit(req_unit), .legal(legal)
  );

  always_comb begin
    req_ready = !out_valid || out_ready;
    accept    = req_valid && req_ready;
    take      = legal && req_pred;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_bad_unit <= 1'b0;
      out_target   <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_taken    <= take;
      out_bad_unit <= !legal;
      if (take) out_target <= req_abs ? abs_tgt : rel_tgt;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_taken) && $stable(out_bad_unit))); // R8

  AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad_unit |-> !out_taken); // R5

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_abs && req_unit != ABS_UNIT) |=> (out_bad_unit && !out_taken)); // R5

  AST_NOT_TAKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> $stable(out_target)); // R6

  AST_ABS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_abs) |=> (out_target[WORD_LSB-1:0] == '0)); // R4
endmodule

// File: tb/tb_btg_top.sv
`timescale 1ns/1ps
module tb_btg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic [20:0] req_disp = '0;
  logic [31:0] req_reg = '0;
  logic        req_abs = 1'b0;
  logic [2:0]  req_unit = '0;
  logic        req_pred = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_target;
  logic        out_taken;
  logic        out_bad_unit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  btg_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_disp(req_disp), .req_reg(req_reg), .req_abs(req_abs),
    .req_unit(req_unit), .req_pred(req_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_target(out_target), .out_taken(out_taken),
    .out_bad_unit(out_bad_unit)
  );

  // {abs, unit[3], pred, pc[32], disp[21], reg[32], exp_taken, exp_bad, exp_tgt[32]}
  localparam int NV = 12;
  localparam logic [123:0] VEC [NV] = '{
    {1'b0, 3'd2, 1'b1, 32'h0000_1234, 21'h000010, 32'h0, 1'b1, 1'b0, 32'h0000_1260}, // R2
    {1'b0, 3'd0, 1'b1, 32'h8000_003F, 21'h1FFFFF, 32'h0, 1'b1, 1'b0, 32'h8000_001C}, // R3 -1 word
    {1'b0, 3'd5, 1'b1, 32'h0040_0000, 21'h100000, 32'h0, 1'b1, 1'b0, 32'h0000_0000}, // R3 most negative
    {1'b0, 3'd3, 1'b1, 32'h0000_0000, 21'h0FFFFF, 32'h0, 1'b1, 1'b0, 32'h003F_FFFC}, // R3 most positive
    {1'b1, 3'd3, 1'b1, 32'h0, 21'h0, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'hDEAD_BEEC},     // R4
    {1'b1, 3'd2, 1'b1, 32'h0, 21'h0, 32'h1234_5678, 1'b0, 1'b1, 32'hDEAD_BEEC},     // R5
    {1'b0, 3'd1, 1'b0, 32'h0000_0100, 21'h000005, 32'h0, 1'b0, 1'b0, 32'hDEAD_BEEC}, // R6
    {1'b1, 3'd3, 1'b0, 32'h0, 21'h0, 32'h1111_1111, 1'b0, 1'b0, 32'hDEAD_BEEC},     // R6
    {1'b0, 3'd4, 1'b1, 32'hFFFF_FFE0, 21'h000008, 32'h0, 1'b1, 1'b0, 32'h0000_0000}, // R3 wrap
    {1'b1, 3'd7, 1'b0, 32'h0, 21'h0, 32'h5555_5555, 1'b0, 1'b1, 32'h0000_0000},     // R5 pred low
    {1'b1, 3'd3, 1'b1, 32'h0, 21'h0, 32'h7FFF_FFFF, 1'b1, 1'b0, 32'h7FFF_FFFC},     // R4
    {1'b0, 3'd3, 1'b1, 32'h1234_5678, 21'h000001, 32'h0, 1'b1, 1'b0, 32'h1234_5664}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [123:0] v);
    req_abs  = v[123];
    req_unit = v[122:120];
    req_pred = v[119];
    req_pc   = v[118:87];
    req_disp = v[86:66];
    req_reg  = v[65:34];
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 out_taken", 32'(out_taken), 32'd0);
    check("R1 out_bad_unit", 32'(out_bad_unit), 32'd0);
    check("R1 out_target", out_target, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 out_valid", 32'(out_valid), 32'd1);
      check("R2/R3/R4 out_target", out_target, VEC[i][31:0]);
      check("R5/R6 out_taken", 32'(out_taken), 32'(VEC[i][33]));
      check("R5 out_bad_unit", 32'(out_bad_unit), 32'(VEC[i][32]));
    end

    // R7: valid drops with no new request while drained
    @(negedge clk);
    check("R7 idle out_valid", 32'(out_valid), 32'd0);

    // R8: back-pressure
    out_ready = 1'b0;
    load({1'b1, 3'd3, 1'b1, 32'h0, 21'h0, 32'hAAAA_AAAB, 34'h0});
    req_valid = 1'b1;
    @(negedge clk);
    check("R8 first target", out_target, 32'hAAAA_AAA8);
    load({1'b1, 3'd3, 1'b1, 32'h0, 21'h0, 32'h0000_0404, 34'h0});
    check("R8 req_ready low", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    check("R8 held target", out_target, 32'hAAAA_AAA8);
    check("R8 held valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    #1;
    check("R8 req_ready when drained", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 pending consumed", out_target, 32'h0000_0404);
    check("R8 pending taken", 32'(out_taken), 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule